// File: doc/BRIEF.md
# Byte-Serial Read Responder

This block sits on the memory side of a narrow shared bus and answers read requests from a bus controller. The requester sends a 32-bit address as four byte beats over an 8-bit bus and marks the first beat with a start strobe. The responder waits a fixed turnaround interval and then drives the addressed 32-bit word back over the same bus as four byte beats. It flags the first data beat with a one-cycle ready pulse.

The bus is split into an input byte, an output byte and an output-enable line. The responder raises the enable only while it returns data, so the requester can drive addresses at all other times. The word store holds 256 words that are filled with a fixed index-derived pattern at reset. An active-low asynchronous reset abandons a transfer at any point and returns the block to idle.

Top module: `byte_bus_responder`

## Requirements
- R1: In idle, a cycle with `start_i` high carries address bits 7:0 on `bus_i`. The next three cycles carry bits 15:8, 23:16 and 31:24, whatever the value of `start_i` in those cycles.
- R2: `ready_o` is high for exactly one cycle per transfer.
- R3: Number the start cycle 0. Then `ready_o` is high in cycle 4 + TURN_CYC (cycle 6 with the default TURN_CYC = 2), and low in the turnaround cycles that come before it.
- R4: Data bits 7:0 are on `bus_o` in the ready cycle. Bits 15:8, 23:16 and 31:24 follow in the next three cycles.
- R5: `bus_oe_o` is high from the ready cycle through the fourth data beat and low at all other times. While `bus_oe_o` is low, `bus_o` is zero.
- R6: The returned word is selected by address bits 9:2, and the other address bits are ignored. For index i, the word is {i^8'h5A, ~i, i, i+8'h11}, with bits 31:24 first in that list.
- R7: A `start_i` pulse that arrives while a transfer is in progress is ignored. No second transfer follows it.
- R8: A reset asserted during the data phase clears `ready_o`, `bus_oe_o` and `bus_o` immediately. After reset is released, the next start is served normally.
- R9: During reset and right after it, `ready_o` and `bus_oe_o` are low and `bus_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first address beat |
| bus_i | input | 8 | Byte driven by the requester |
| bus_o | output | 8 | Byte driven by the responder |
| bus_oe_o | output | 1 | Responder drives the bus |
| ready_o | output | 1 | First data beat is on the bus |

## Verification
The assertions assume that the requester respects the protocol. It sends four address beats back to back, and it does not drive the bus during the responder's return window. The bench always sends the full four-beat address phase and waits until the data phase has ended before it starts the next request. It only pulses `start_i` inside a busy window to exercise the ignore rule. Addresses and the position of each stray start are drawn with `$urandom` from a fixed seed. Directed cases cover a reset that lands in the middle of the data phase and the extreme values of the index.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_TURN, PH_DATA} phase_e;

  function automatic logic [31:0] fill_word(input logic [7:0] i);
    fill_word = {i ^ 8'h5A, ~i, i, i + 8'h11};
  endfunction
endpackage

// File: rtl/bbr_addr_deser.sv
module bbr_addr_deser #(
  parameter int BYTE_W = 8,
  parameter int BEATS  = 4,
  localparam int WORD_W = BYTE_W * BEATS,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_o <= '0;
    else if (cap_i) addr_o[idx_i*BYTE_W +: BYTE_W] <= byte_i;
  end
endmodule

// File: rtl/bbr_word_store.sv
module bbr_word_store #(
  parameter int WORD_W = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              unused_addr;

  assign idx         = addr_i[IDX_LO +: IDX_W];
  assign unused_addr = ^{addr_i[WORD_W-1:IDX_LO+IDX_W], addr_i[IDX_LO-1:0]};

  // read-only store, loaded with the index pattern at reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++)
        mem_q[k] <= WORD_W'(bbr_pkg::fill_word(8'(k)));
    end
  end

  assign word_o = mem_q[idx];
endmodule

// File: rtl/bbr_beat_mux.sv
module bbr_beat_mux #(
  parameter int BYTE_W = 8,
  parameter int BEATS  = 4,
  localparam int WORD_W = BYTE_W * BEATS,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              en_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lane [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = en_i ? lane[beat_i] : '0;
endmodule

// File: rtl/byte_bus_responder.sv
module byte_bus_responder #(
  parameter int BYTE_W   = 8,
  parameter int BEATS    = 4,
  parameter int TURN_CYC = 2,
  parameter int IDX_LO   = 2,
  parameter int IDX_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] bus_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              ready_o
);
  import bbr_pkg::*;

  localparam int WORD_W = BYTE_W * BEATS;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int TW     = $clog2(TURN_CYC);
  localparam int CNT_W  = (TW > BEAT_W) ? TW : BEAT_W;

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cap;
  logic [BEAT_W-1:0] cap_idx;
  logic [WORD_W-1:0] addr;
  logic [WORD_W-1:0] word;
  logic              driving;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_ADDR;
          cnt_q   <= CNT_W'(1);
        end
        PH_ADDR: if (cnt_q == CNT_W'(BEATS - 1)) begin
          phase_q <= PH_TURN;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_TURN: if (cnt_q == CNT_W'(TURN_CYC - 1)) begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_DATA: if (cnt_q == CNT_W'(BEATS - 1)) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // start is only honoured from idle
  assign cap     = (phase_q == PH_IDLE && start_i) || phase_q == PH_ADDR;
  assign cap_idx = (phase_q == PH_IDLE) ? '0 : cnt_q[BEAT_W-1:0];
  assign driving = phase_q == PH_DATA;

  bbr_addr_deser #(.BYTE_W(BYTE_W), .BEATS(BEATS)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .idx_i  (cap_idx),
    .byte_i (bus_i),
    .addr_o (addr)
  );

  bbr_word_store #(.WORD_W(WORD_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr),
    .word_o (word)
  );

  bbr_beat_mux #(.BYTE_W(BYTE_W), .BEATS(BEATS)) u_mux (
    .word_i (word),
    .beat_i (cnt_q[BEAT_W-1:0]),
    .en_i   (driving),
    .byte_o (bus_o)
  );

  assign bus_oe_o = driving;
  assign ready_o  = driving && cnt_q == '0;
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int BYTE_W = 8,
  parameter int BEATS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              bus_oe_o,
  input logic [BYTE_W-1:0] bus_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (bus_oe_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  AST_READY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R2
  AST_READY_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> bus_oe_o); // R4
  AST_OE_OPENS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> ready_o); // R5
  AST_OE_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) |-> run_q == 8'(BEATS)); // R5
  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0); // R5
endmodule

bind byte_bus_responder bbr_checker #(.BYTE_W(BYTE_W), .BEATS(BEATS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .bus_oe_o (bus_oe_o),
  .bus_o    (bus_o)
);

// File: tb/byte_bus_responder_bench.sv
`timescale 1ns/1ps
module byte_bus_responder_bench;
  localparam int TURN = 2;
  localparam int RC   = 4 + TURN;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       start_i = 0;
  logic [7:0] bus_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe_o, ready_o;
  int         checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  byte_bus_responder #(.TURN_CYC(TURN)) u_byte_bus_responder (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .ready_o(ready_o)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [7:0] i = a[9:2];
    return {i ^ 8'h5A, ~i, i, i + 8'h11};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // busy: cycle index 1..RC+3 with a stray start, 0 for none
  task automatic do_read(input logic [31:0] a, input int busy);
    logic [31:0] w = exp_word(a);
    for (int c = 0; c <= RC + 8; c++) begin
      @(negedge clk_i);
      start_i = (c == 0) || (busy != 0 && c == busy);
      bus_i   = (c < 4) ? a[c*8 +: 8] : 8'($urandom);
      #1;
      if (c >= 4) begin
        logic dr = (c >= RC && c < RC + 4);
        check(c == RC ? "R3 ready" : "R2 ready", 32'(ready_o), 32'(c == RC));
        check(busy != 0 && c >= RC + 4 ? "R7 oe" : "R5 oe", 32'(bus_oe_o), 32'(dr));
        check("R1/R4/R6 data", 32'(bus_o), dr ? 32'(w[(c-RC)*8 +: 8]) : 32'd0);
      end
    end
    start_i = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R9 ready", 32'(ready_o), 0);
    check("R9 oe", 32'(bus_oe_o), 0);
    check("R9 bus", 32'(bus_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    check("R9 oe after", 32'(bus_oe_o), 0);

    do_read(32'h0000_0000, 0);
    do_read(32'hFFFF_FFFF, 0);
    do_read(32'hABCD_EF03, 2);          // R6 upper and low bits ignored
    do_read(32'h1234_0004, RC + 1);     // R7 stray start in data phase

    // R8 reset mid data phase
    begin
      logic [31:0] a = 32'h0000_0150;
      for (int c = 0; c <= RC + 1; c++) begin
        @(negedge clk_i);
        start_i = (c == 0);
        bus_i   = (c < 4) ? a[c*8 +: 8] : 8'h00;
      end
      rst_ni = 0;
      #1;
      check("R8 ready", 32'(ready_o), 0);
      check("R8 oe", 32'(bus_oe_o), 0);
      check("R8 bus", 32'(bus_o), 0);
      @(negedge clk_i);
      rst_ni = 1;
      do_read(32'h0000_03FC, 0);        // R8 serves normally afterwards
    end

    for (int n = 0; n < 40; n++) begin
      int b = ($urandom % 3 == 0) ? 1 + ($urandom % (RC + 3)) : 0;
      do_read($urandom, b);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule